// File: doc/BRIEF.md
# Cascadable Timer Compare Unit

This unit holds the counters, compare registers and mode control of a two-stage timer. A narrow low stage and a wider high stage either form one long counter (joined mode) or run as a divider feeding a second counter (split mode). In split mode, each compare match of the low stage advances the high stage by one. All counting happens on cycles where the external `tick` enable is high.

A compare match or a counter overflow can have three effects: it can toggle an output flip-flop, it can clear the counter, and it can raise a one-cycle interrupt pulse. A 4-bit mode register sets which of these happen. The output mode chooses whether the interrupt follows the match or the overflow. While software is loading a compare register, that register cannot produce a match. In prescaler mode, a zero in the low compare register makes every tick go straight to the high stage.

All registers are written through one nibble-wide port that has a select field. The high compare register takes two writes in turn.

Top module: `timer_cmp_unit`

## Requirements
- R1: After a synchronous reset, `count` is 0, `tog_out` and `irq` are 0, the mode register is 0000, and both compare registers hold all ones. In joined mode, the compare value is therefore 0xFFF.
- R2: A write (`wr_en`=1) with `wr_sel`=0 loads the mode register. Its bit 3 enables toggle on overflow, bit 2 enables toggle on match, bit 1 clears the counter on match, and bit 0 enables the interrupt. `wr_sel`=1 loads the low compare register. `wr_sel`=2 loads the high compare register in two writes: the first fills bits 3..0 and the next fills bits 7..4. `wr_sel`=3 writes nothing.
- R3: In joined mode (`join_en`=1), each tick increments the 12-bit `count`. A match is a tick on which `count` equals {high compare, low compare}.
- R4: In split mode, the low stage (`count[3:0]`) counts ticks and clears on the tick where it equals the low compare value. That same tick advances the high stage (`count[11:4]`), whose match is against the high compare register.
- R5: If bit 1 of the mode register is 1, a match makes the next counter value 0. If it is 0, the counter keeps incrementing through the match.
- R6: `tog_out` inverts on the edge after a match when bit 2 is set. It also inverts after an overflow when bit 3 is set. If both events occur together with both bits set, it inverts once.
- R7: An overflow is an advance of the active counter from all ones. In joined mode the counter is 12 bits wide; in split mode it is the 8-bit high stage. On an overflow the counter becomes 0.
- R8: `irq` is registered and pulses for one cycle after an event. The event is an overflow when bit 3 is set and `out_mode` is not 7. In every other case it is a match. No pulse occurs unless bit 0 is set.
- R9: In split mode with `presc_en`=1 and a low compare value of 0, every tick advances the high stage, and the low stage stays at 0.
- R10: A compare register produces no match on a cycle that writes it. The high register also produces no match between its first and second nibble writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable from the prescaler |
| join_en | input | 1 | 1: single 12-bit counter; 0: split stages |
| presc_en | input | 1 | Prescaler mode; allows the low-stage bypass |
| out_mode | input | 3 | Output mode; 7 forces the match as interrupt source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 mode, 1 low compare, 2 high compare |
| wr_data | input | 4 | Write nibble |
| tog_out | output | 1 | Toggle flip-flop |
| irq | output | 1 | One-cycle interrupt pulse |
| count | output | 12 | {high stage, low stage} counter value |

## Verification
The assertions assume that `join_en`, `presc_en` and `out_mode` change only between runs. They also assume that high-register writes come in pairs without a reset between the two halves. The stimulus keeps to this: it changes the configuration only between groups of ticks, and it writes both halves before it relies on a new compare value. The one deliberate exception leaves a first half pending across many ticks to show that the match stays suppressed.

// File: rtl/timer_cmp_unit.sv
module timer_cmp_unit #(
  parameter int LO_W = 4,
  parameter int HI_W = 2 * LO_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 join_en,
  input  logic                 presc_en,
  input  logic [2:0]           out_mode,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [LO_W-1:0]      wr_data,
  output logic                 tog_out,
  output logic                 irq,
  output logic [LO_W+HI_W-1:0] count
);
  localparam int CW = LO_W + HI_W;
  localparam int HALF = HI_W / 2;

  logic [3:0]      mode_q;
  logic [LO_W-1:0] lo_cmp, lo_cnt;
  logic [HI_W-1:0] hi_cmp, hi_cnt;
  logic            hi_ph;

  wire otm = mode_q[3];
  wire ctm = mode_q[2];
  wire rm  = mode_q[1];
  wire im  = mode_q[0];

  wire lo_busy  = wr_en && wr_sel == 2'd1;
  wire hi_busy  = (wr_en && wr_sel == 2'd2) || hi_ph;
  wire bypass   = !join_en && presc_en && lo_cmp == '0;

  wire j_match  = tick && count == {hi_cmp, lo_cmp} && !lo_busy && !hi_busy;
  wire j_ovf    = tick && &count;
  wire lo_match = !bypass && tick && lo_cnt == lo_cmp && !lo_busy;
  wire hi_en    = bypass ? tick : lo_match;
  wire hi_match = hi_en && hi_cnt == hi_cmp && !hi_busy;
  wire hi_ovf   = hi_en && &hi_cnt;

  wire match    = join_en ? j_match : hi_match;
  wire ovf      = join_en ? j_ovf : hi_ovf;
  wire src_ovf  = otm && out_mode != 3'd7;

  assign count = {hi_cnt, lo_cnt};

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else if (join_en) begin
      if (tick) {hi_cnt, lo_cnt} <= (match && rm) ? CW'(0) : CW'(count + 1'b1);
    end else begin
      if (bypass)    lo_cnt <= '0;
      else if (tick) lo_cnt <= lo_match ? '0 : lo_cnt + 1'b1;
      if (hi_en)     hi_cnt <= (hi_match && rm) ? '0 : hi_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      lo_cmp <= '1;
      hi_cmp <= '1;
      hi_ph  <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: mode_q <= wr_data;
        2'd1: lo_cmp <= wr_data;
        2'd2: begin
          if (hi_ph) hi_cmp[HI_W-1:HALF] <= wr_data;
          else       hi_cmp[HALF-1:0]    <= wr_data;
          hi_ph <= !hi_ph;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_out <= 1'b0;
      irq     <= 1'b0;
    end else begin
      tog_out <= tog_out ^ ((otm && ovf) || (ctm && match));
      irq     <= im && (src_ovf ? ovf : match);
    end
  end

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(im));

  // R5
  clear_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    (match && rm) |=> (join_en ? count == '0 : hi_cnt == '0));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (join_en && j_ovf) |=> count == '0);

  // R10
  pending_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hi_ph && !otm) |=> $stable(tog_out));

  // R9
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (bypass && tick && !wr_en) |=> lo_cnt == '0);
endmodule

// File: tb/timer_cmp_unit_tb_top.sv
module timer_cmp_unit_tb_top;
  localparam int PERIOD = 10;

  typedef struct {
    logic        tog;
    logic        irq;
    logic [11:0] cnt;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1, tick = 1'b0, join_en = 1'b1, presc_en = 1'b0, wr_en = 1'b0;
  logic [2:0]  out_mode = 3'd1;
  logic [1:0]  wr_sel = 2'd3;
  logic [3:0]  wr_data = '0;
  logic        tog_out, irq;
  logic [11:0] count;

  exp_t q[$];
  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [3:0] m_mode, m_lc, m_lo;
  logic [7:0] m_hc, m_hi;
  logic m_ph, m_tog, m_irq;

  always #(PERIOD/2) clk = ~clk;

  timer_cmp_unit dut_i (
    .clk(clk), .rst(rst), .tick(tick), .join_en(join_en), .presc_en(presc_en),
    .out_mode(out_mode), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tog_out(tog_out), .irq(irq), .count(count)
  );

  task automatic step(input logic r, input logic c, input logic w,
                      input logic [1:0] s, input logic [3:0] d, input string t);
    logic bl, bh, byp, lm, hen, mt, ov;
    logic [11:0] cv;
    exp_t e;
    @(negedge clk);
    rst = r; tick = c; wr_en = w; wr_sel = s; wr_data = d;
    if (r) begin
      m_mode = 0; m_lo = 4'hF; m_hi = 8'hFF; m_ph = 0;
      m_lc = 0; m_hc = 0; m_tog = 0; m_irq = 0;
    end else begin
      bl = w && s == 2'd1;
      bh = (w && s == 2'd2) || m_ph;
      cv = {m_hc, m_lc};
      if (join_en) begin
        mt = c && cv == {m_hi, m_lo} && !bl && !bh;
        ov = c && cv == 12'hFFF;
        if (c) cv = (mt && m_mode[1]) ? 12'h0 : cv + 12'h1;
        {m_hc, m_lc} = cv;
      end else begin
        byp = presc_en && m_lo == 0;
        lm  = !byp && c && m_lc == m_lo && !bl;
        hen = byp ? c : lm;
        mt  = hen && m_hc == m_hi && !bh;
        ov  = hen && m_hc == 8'hFF;
        if (byp) m_lc = 0;
        else if (c) m_lc = lm ? 4'h0 : m_lc + 4'h1;
        if (hen) m_hc = (mt && m_mode[1]) ? 8'h0 : m_hc + 8'h1;
      end
      m_tog = m_tog ^ ((m_mode[3] && ov) || (m_mode[2] && mt));
      m_irq = m_mode[0] && ((m_mode[3] && out_mode != 3'd7) ? ov : mt);
      if (w) begin
        if (s == 2'd0) m_mode = d;
        else if (s == 2'd1) m_lo = d;
        else if (s == 2'd2) begin
          if (m_ph) m_hi[7:4] = d; else m_hi[3:0] = d;
          m_ph = !m_ph;
        end
      end
    end
    e.tog = m_tog; e.irq = m_irq; e.cnt = {m_hc, m_lc}; e.tag = t;
    q.push_back(e);
  endtask

  task automatic ticks(input int n, input string t);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, 2'd3, 4'h0, t);
  endtask

  task automatic wr(input logic [1:0] s, input logic [3:0] d, input string t);
    step(1'b0, 1'b0, 1'b1, s, d, t);
  endtask

  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      nchk++;
      if (tog_out !== e.tog || irq !== e.irq || count !== e.cnt) begin
        nfail++;
        $display("FAIL %s: got tog=%b irq=%b cnt=%h, expected tog=%b irq=%b cnt=%h",
                 e.tag, tog_out, irq, count, e.tog, e.irq, e.cnt);
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    step(1'b1, 1'b0, 1'b0, 2'd3, 4'h0, "R1");
    step(1'b1, 1'b0, 1'b0, 2'd3, 4'h0, "R1");
    step(1'b0, 1'b0, 1'b0, 2'd3, 4'h0, "R1");
    // R1: default compare 0xFFF in joined mode, clear + irq on match
    wr(2'd0, 4'b0011, "R2");
    ticks(4100, "R1");
    // R3 / R6: compare 0x013 with toggle on match
    wr(2'd1, 4'h3, "R2");
    wr(2'd2, 4'h1, "R2");
    wr(2'd2, 4'h0, "R2");
    wr(2'd0, 4'b0111, "R2");
    ticks(45, "R6");
    // R5: count through the match
    wr(2'd0, 4'b0101, "R5");
    ticks(30, "R5");
    // R7: overflow as interrupt source with overflow toggle
    wr(2'd0, 4'b1001, "R7");
    ticks(4100, "R7");
    // R8: mode 7 forces match as source
    out_mode = 3'd7;
    wr(2'd0, 4'b1101, "R8");
    ticks(4100, "R8");
    wr(2'd0, 4'b0011, "R8");
    ticks(40, "R8");
    out_mode = 3'd2;
    wr(2'd0, 4'b0110, "R8");
    ticks(50, "R8");
    // R4: split mode divider
    join_en = 1'b0;
    wr(2'd1, 4'h2, "R4");
    wr(2'd2, 4'h1, "R4");
    wr(2'd2, 4'h0, "R4");
    wr(2'd0, 4'b0111, "R4");
    ticks(40, "R4");
    // R9: bypass in prescaler mode
    presc_en = 1'b1;
    wr(2'd1, 4'h0, "R9");
    ticks(20, "R9");
    presc_en = 1'b0;
    ticks(10, "R9");
    // R10: pending high write blocks matches
    wr(2'd1, 4'h1, "R10");
    wr(2'd2, 4'h0, "R10");
    ticks(30, "R10");
    wr(2'd2, 4'h0, "R10");
    ticks(20, "R4");
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b1, 2'd1, 4'h1, "R10");
    ticks(10, "R10");
    // R7: split overflow of high stage
    wr(2'd1, 4'h0, "R7");
    wr(2'd2, 4'h0, "R7");
    wr(2'd2, 4'h8, "R7");
    wr(2'd0, 4'b1001, "R7");
    presc_en = 1'b1;
    ticks(300, "R7");
    presc_en = 1'b0;
    step(1'b1, 1'b0, 1'b0, 2'd3, 4'h0, "R1");
    step(1'b0, 1'b0, 1'b0, 2'd3, 4'h0, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule